// File: doc/BRIEF.md
# Three-Wire Serial Clock Access Interface

This block is the host side of a real-time clock's serial port. A host drives a chip-enable, a shift clock, a direction select and one data line. With direction low, the rising edge of chip-enable freezes a copy of the calendar registers into a shift register, and the host clocks that copy out one bit at a time, least significant bit first. With direction high, the host clocks new calendar values in. When chip-enable falls, the block hands them to the calendar counter with a one-cycle strobe. The counter then clears its seconds and restarts its prescaler.

All pins are sampled into the system clock domain through a short synchronizer. Edges are found from the synchronized levels. The data line is brought out as separate in, out and output-enable signals, for a pad cell at chip level. A low-supply flag from the supply monitor replaces the snapshot with a warning pattern. Calendar counting itself is outside this block.

Top module: `rtc_sio_port`

## Requirements
- R1: After reset, `data_oe_o`, `commit_o` and `presc_clr_o` are low.
- R2: `data_oe_o` is high only while an access that began with chip-enable rising and `dir_i` low (read) is open. During a write, and with chip-enable low, the data line is released.
- R3: On chip-enable rising with `dir_i` low, `rd_time_i` is captured and its bit 0 appears on `data_o`.
- R4: Each falling edge of `sclk_i` during a read moves `data_o` to the next bit, so the stream is `rd_time_i` bits 0 to 51. The fields are: year [7:0], month [15:8], day [23:16], weekday [27:24], hour [35:28], minute [43:36], second [51:44], all BCD.
- R5: Changes on `rd_time_i` after the capture do not alter the bits being streamed.
- R6: If `low_supply_i` is high at capture, every nibble of the captured word is 4'hE, so every byte reads 0xEE.
- R7: During a write, `data_i` is sampled on each rising edge of `sclk_i`. The register keeps the most recent 44 bits, with the oldest of them at bit 0 of `wr_time_o`. The field layout is the same as bits [43:0] of R4 (year to minute).
- R8: Chip-enable falling at the end of a write gives exactly one `commit_o` pulse of one cycle, with `wr_time_o` valid in that cycle. A read access gives no pulse.
- R9: `presc_clr_o` is high for the whole of a write access and low otherwise. This holds the prescaler cleared and stops updates until the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip-enable from host |
| sclk_i | input | 1 | Serial shift clock from host |
| dir_i | input | 1 | Direction: 1 write, 0 read |
| data_i | input | 1 | Serial data from host |
| data_o | output | 1 | Serial data to host |
| data_oe_o | output | 1 | Output enable for the data pad |
| low_supply_i | input | 1 | Low-supply flag |
| rd_time_i | input | 52 | Current calendar value (R4 layout) |
| wr_time_o | output | 44 | Written calendar value, year to minute |
| commit_o | output | 1 | One-cycle load strobe for the counter |
| presc_clr_o | output | 1 | Prescaler clear / update hold level |

## Verification
On every cycle, the assertions check these properties:
- the output enable and the prescaler clear are never high together;
- the commit strobe lasts one cycle and only closes a write;
- a capture turns on the output;
- the shift register does not move without a load or shift;
- each read shift exposes the next stored bit;
- the direction is fixed for the whole of an access.

Other behaviour can only be shown by the bench scenarios:
- the full 52-bit field order;
- the frozen snapshot while `rd_time_i` keeps changing;
- the 0xEE substitution;
- the keep-the-newest-44 rule for over-long writes;
- the write-then-read round trip.

// File: rtl/rtc_sio_pkg.sv
package rtc_sio_pkg;
  localparam int unsigned PIN_CE   = 0;
  localparam int unsigned PIN_SCLK = 1;
  localparam int unsigned PIN_DIR  = 2;
  localparam int unsigned PIN_DATA = 3;
  localparam int unsigned PIN_W    = 4;
  localparam logic [3:0]  WARN_NIB = 4'hE;
endpackage

// File: rtl/rtc_sio_sync.sv
module rtc_sio_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= stg[STAGES-1];

  assign lvl_o = stg[STAGES-1];
endmodule

// File: rtl/rtc_sio_ctrl.sv
module rtc_sio_ctrl
  import rtc_sio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIN_W-1:0] lvl_i,
  input  logic [PIN_W-1:0] prev_i,
  output logic             load_o,
  output logic             rd_shift_o,
  output logic             wr_shift_o,
  output logic             oe_o,
  output logic             presc_clr_o,
  output logic             commit_o
);
  logic active_q, wr_q;
  logic ce_rise, ce_fall, sclk_rise, sclk_fall;

  assign ce_rise   =  lvl_i[PIN_CE]   & ~prev_i[PIN_CE];
  assign ce_fall   = ~lvl_i[PIN_CE]   &  prev_i[PIN_CE];
  assign sclk_rise =  lvl_i[PIN_SCLK] & ~prev_i[PIN_SCLK];
  assign sclk_fall = ~lvl_i[PIN_SCLK] &  prev_i[PIN_SCLK];

  assign load_o     = ce_rise & ~lvl_i[PIN_DIR];
  assign rd_shift_o = active_q & ~wr_q & lvl_i[PIN_CE] & sclk_fall;
  assign wr_shift_o = active_q &  wr_q & lvl_i[PIN_CE] & sclk_rise;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      commit_o <= 1'b0;
    end else begin
      commit_o <= active_q & wr_q & ce_fall;
      if (ce_rise) begin
        active_q <= 1'b1;
        wr_q     <= lvl_i[PIN_DIR];
      end else if (ce_fall) begin
        active_q <= 1'b0;
      end
    end

  assign oe_o        = active_q & ~wr_q;
  assign presc_clr_o = active_q &  wr_q;

  AST_DIR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(oe_o && presc_clr_o)); // R2
  AST_LOAD_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> oe_o); // R3
  AST_COMMIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o); // R8
  AST_COMMIT_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(presc_clr_o) && !presc_clr_o); // R8
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !ce_rise) |=> $stable(wr_q)); // R9
  AST_CE_SCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_rise || ce_fall) |-> !lvl_i[PIN_SCLK]); // R3
  AST_DIR_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_rise |-> lvl_i[PIN_DIR] == prev_i[PIN_DIR]); // R3
  AST_DATA_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_shift_o |-> lvl_i[PIN_DATA] == prev_i[PIN_DATA]); // R7
endmodule

// File: rtl/rtc_sio_shreg.sv
module rtc_sio_shreg
  import rtc_sio_pkg::*;
#(
  parameter int unsigned RD_BITS = 52,
  parameter int unsigned WR_BITS = 44
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               low_supply_i,
  input  logic [RD_BITS-1:0] rd_time_i,
  input  logic               rd_shift_i,
  input  logic               wr_shift_i,
  input  logic               wr_bit_i,
  output logic               ser_o,
  output logic [WR_BITS-1:0] wr_word_o
);
  localparam int unsigned NIBS = RD_BITS / 4;
  localparam logic [RD_BITS-1:0] WARN_WORD = {NIBS{WARN_NIB}};

  logic [RD_BITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         sh_q <= '0;
    else if (load_i)     sh_q <= low_supply_i ? WARN_WORD : rd_time_i;
    else if (rd_shift_i) sh_q <= {1'b0, sh_q[RD_BITS-1:1]};
    else if (wr_shift_i) sh_q[WR_BITS-1:0] <= {wr_bit_i, sh_q[WR_BITS-1:1]};

  assign ser_o     = sh_q[0];
  assign wr_word_o = sh_q[WR_BITS-1:0];

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !rd_shift_i && !wr_shift_i) |=> $stable(sh_q)); // R5
  AST_RD_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_shift_i |=> ser_o == $past(sh_q[1])); // R4
  AST_WR_NEWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_shift_i |=> wr_word_o[WR_BITS-1] == $past(wr_bit_i)); // R7
endmodule

// File: rtl/rtc_sio_port.sv
module rtc_sio_port
  import rtc_sio_pkg::*;
#(
  parameter int unsigned RD_BITS     = 52,
  parameter int unsigned WR_BITS     = 44,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_i,
  input  logic               sclk_i,
  input  logic               dir_i,
  input  logic               data_i,
  output logic               data_o,
  output logic               data_oe_o,
  input  logic               low_supply_i,
  input  logic [RD_BITS-1:0] rd_time_i,
  output logic [WR_BITS-1:0] wr_time_o,
  output logic               commit_o,
  output logic               presc_clr_o
);
  logic [PIN_W-1:0] pins, lvl, prev;
  logic load, rd_shift, wr_shift, ser;

  always_comb begin
    pins           = '0;
    pins[PIN_CE]   = ce_i;
    pins[PIN_SCLK] = sclk_i;
    pins[PIN_DIR]  = dir_i;
    pins[PIN_DATA] = data_i;
  end

  rtc_sio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i(pins), .lvl_o(lvl), .prev_o(prev)
  );

  rtc_sio_ctrl u_ctrl (
    .clk_i, .rst_ni, .lvl_i(lvl), .prev_i(prev),
    .load_o(load), .rd_shift_o(rd_shift), .wr_shift_o(wr_shift),
    .oe_o(data_oe_o), .presc_clr_o(presc_clr_o), .commit_o(commit_o)
  );

  rtc_sio_shreg #(.RD_BITS(RD_BITS), .WR_BITS(WR_BITS)) u_shreg (
    .clk_i, .rst_ni, .load_i(load), .low_supply_i(low_supply_i),
    .rd_time_i(rd_time_i), .rd_shift_i(rd_shift), .wr_shift_i(wr_shift),
    .wr_bit_i(lvl[PIN_DATA]), .ser_o(ser), .wr_word_o(wr_time_o)
  );

  assign data_o = data_oe_o & ser;

  AST_OE_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !presc_clr_o && !commit_o); // R2
endmodule

// File: tb/rtc_sio_port_tb_top.sv
module rtc_sio_port_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce = 0, sclk = 0, dir = 0, din = 0, low = 0;
  logic [51:0] rd_time = '0;
  logic dout, oe, commit, pclr;
  logic [43:0] wr_time;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_sio_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce), .sclk_i(sclk), .dir_i(dir),
    .data_i(din), .data_o(dout), .data_oe_o(oe), .low_supply_i(low),
    .rd_time_i(rd_time), .wr_time_o(wr_time), .commit_o(commit),
    .presc_clr_o(pclr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_c(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [51:0] warn_word();
    return {13{4'hE}};
  endfunction

  function automatic logic [43:0] last44(input logic [63:0] b, input int n);
    logic [43:0] r;
    for (int j = 0; j < 44; j++) r[j] = b[n - 44 + j];
    return r;
  endfunction

  // read access; optionally scramble rd_time after capture (R5)
  task automatic do_read(input bit scramble, output logic [51:0] s);
    dir = 0; wait_c(2);
    ce = 1; wait_c(6);
    chk(oe === 1'b1, "R2 oe in read", oe, 1);
    s[0] = dout;
    if (scramble) rd_time = {$urandom, $urandom};
    for (int i = 1; i < 52; i++) begin
      sclk = 1; wait_c(5);
      sclk = 0; wait_c(5);
      s[i] = dout;
      if (scramble && i % 8 == 0) rd_time = {$urandom, $urandom};
    end
    ce = 0; wait_c(6);
    chk(oe === 1'b0, "R2 oe after ce fall", oe, 0);
  endtask

  task automatic do_write(input int n, input logic [63:0] bits,
                          output int pulses, output logic [43:0] word);
    dir = 1; wait_c(2);
    ce = 1; wait_c(6);
    chk(pclr === 1'b1, "R9 presc_clr during write", pclr, 1);
    chk(oe === 1'b0, "R2 released during write", oe, 0);
    for (int i = 0; i < n; i++) begin
      din = bits[i]; wait_c(3);
      sclk = 1; wait_c(5);
      sclk = 0; wait_c(3);
    end
    chk(pclr === 1'b1, "R9 presc_clr held", pclr, 1);
    pulses = 0; word = '0;
    ce = 0;
    for (int k = 0; k < 12; k++) begin
      wait_c(1);
      if (commit) begin pulses++; word = wr_time; end
    end
    chk(pclr === 1'b0, "R9 presc_clr released", pclr, 0);
    dir = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [51:0] s, exp;
    logic [63:0] bits;
    logic [43:0] word;
    int pulses, n, cpulse;
    void'($urandom(32'h5eed_0711));
    wait_c(3);
    chk(oe === 1'b0, "R1 oe reset", oe, 0);
    chk(commit === 1'b0, "R1 commit reset", commit, 0);
    chk(pclr === 1'b0, "R1 presc_clr reset", pclr, 0);
    rst_ni = 1; wait_c(3);

    // directed: walking pattern with fields year..second
    rd_time = {8'h59, 8'h47, 8'h23, 4'h6, 8'h31, 8'h12, 8'h99};
    exp = rd_time;
    do_read(0, s);
    chk(s === exp, "R3 R4 directed stream", s, exp);

    // random reads, with and without scrambling after capture
    for (int t = 0; t < 6; t++) begin
      rd_time = {$urandom, $urandom};
      exp = rd_time;
      cpulse = 0;
      do_read(t[0], s);
      chk(s === exp, t[0] ? "R5 frozen snapshot" : "R4 random stream", s, exp);
      chk(commit === 1'b0, "R8 no commit on read", commit, 0);
    end

    // low supply warning
    low = 1;
    rd_time = {$urandom, $urandom};
    do_read(0, s);
    chk(s === warn_word(), "R6 warning pattern", s, warn_word());
    low = 0;

    // writes: exact 44 and over-long windows
    for (int t = 0; t < 6; t++) begin
      n = (t == 0) ? 44 : 44 + ($urandom % 20);
      bits = {$urandom, $urandom};
      do_write(n, bits, pulses, word);
      chk(pulses == 1, "R8 single commit pulse", pulses, 1);
      chk(word === last44(bits, n), "R7 newest 44 bits", word, last44(bits, n));
    end

    // round trip: written value fed back as counter value, seconds cleared
    bits = {20'h0, 8'h58, 8'h09, 4'h3, 8'h28, 8'h02, 8'h24};
    do_write(44, bits, pulses, word);
    chk(pulses == 1, "R8 round trip commit", pulses, 1);
    rd_time = {8'h00, word};
    exp = {8'h00, bits[43:0]};
    do_read(0, s);
    chk(s === exp, "R7 R4 round trip", s, exp);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule